// File: doc/BRIEF.md
# Separate-Port Double-Data-Rate Burst-of-Two Static Memory

This block is a synthesizable model of a synchronous static memory with a read port and a write port that work independently. Every read or write command moves a fixed burst of two data words. The words travel at double data rate, one per half of the command cycle. The model runs on one internal clock at twice the command-clock rate. The input `k_phase` tells it which half cycle each edge belongs to. A value of 1 marks the command-clock rising half, and 0 marks the complementary rising half. The caller drives `k_phase` as a strict alternation.

The array stores word pairs, so each address names one pair and the burst always covers both words of that pair. A write command comes with its first data beat and first-beat lane strobes. The write address, second data beat and second-beat strobes arrive half a cycle later, and the pair is committed on that edge with a per-lane merge. A read command returns the pair on `dout` as two consecutive half-cycle beats, starting 1.5 command cycles after the command, with `dout_valid` marking each beat.

A read issued in the same command cycle as a write to the same pair returns the new contents, byte-merged with the old contents. Reads and writes to different pairs in the same cycle do not affect each other.

Top module: `sp_burst2_sram`

## Requirements
- R1: While reset is held and after it is released, `dout_valid` is 0 and `dout` is 0 until the first read data is driven.
- R2: `rd_n`, `rd_addr`, `wr_n`, the first-beat `bw_n` and the first-beat `din` are sampled only on edges where `k_phase` is 1. On edges where `k_phase` is 0, `rd_n`, `rd_addr` and `wr_n` have no effect. `k_phase` alternates 1, 0, 1, 0 while out of reset.
- R3: `wr_addr`, the second-beat `bw_n` and the second-beat `din` are sampled on the `k_phase`=0 edge that follows the write command. `wr_addr` on a `k_phase`=1 edge has no effect.
- R4: `bw_n` is active low. Bit i enables lane i, which is `din[9i+8:9i]`. The strobes are evaluated separately for each beat, so each beat writes only its enabled lanes of the matching word, and disabled lanes keep their old contents.
- R5: A write command whose strobes are all high on both beats changes nothing in the array.
- R6: When `wr_n` is 1 on a `k_phase`=1 edge, nothing is written, whatever the strobes and data are.
- R7: A read command sampled on edge E0 drives word 0 of the pair (the word written by the first beat) on `dout` from edge E0+3, and word 1 from edge E0+4.
- R8: `dout_valid` is high for exactly two clocks per read command. Reads on consecutive command cycles give an unbroken stream of valid beats.
- R9: A read and a write issued in the same command cycle to different pairs do not interfere. The read returns the old contents of its own pair, and the write lands in full.
- R10: A read issued in the same command cycle as a write to the same pair returns the written lanes merged with the old lanes. A read issued one command cycle before such a write returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_phase | input | 1 | 1 on command-rising half edges, 0 on complementary half edges |
| rd_n | input | 1 | Read command, active low |
| rd_addr | input | ADDR_W | Read pair address |
| wr_n | input | 1 | Write command, active low |
| wr_addr | input | ADDR_W | Write pair address, taken half a cycle after the command |
| bw_n | input | LANES | Per-lane write strobes, active low, per beat |
| din | input | LANES*LANE_W | Write data, one beat per half cycle |
| dout | output | LANES*LANE_W | Read data, one beat per half cycle |
| dout_valid | output | 1 | High while `dout` carries a read beat |

## Verification
The bench drives deliberate garbage on the half-cycle edges where an input should be ignored. This includes active command strobes and a shifted write address, so a design that samples on the wrong phase writes the wrong pair or emits extra beats. It writes pairs with different strobe patterns on each beat, which catches a design that reuses the first-beat strobes for the second beat and so corrupts lanes that should be kept. Same-cycle read/write pairs, to the same and to different addresses, expose a fetch taken before the write commits (stale data) or taken from the wrong address. Back-to-back reads check, beat by beat, the exact edge of every word, so an off-by-one latency or a gap between bursts shows up as a mismatch.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   // Words moved by one command
   localparam int BEATS = 2;

   // Which half of the command cycle the current edge closes
   typedef enum logic {
      PH_FALL = 1'b0,
      PH_RISE = 1'b1
   } kphase_e;
endpackage

// File: rtl/sbs_cmd_capture.sv
// Registers everything sampled on the command-rising half edge.
module sbs_cmd_capture
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              k_phase,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic [DATA_W-1:0] din,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr_q,
   output logic              wr_req,
   output logic [LANES-1:0]  be0_q,
   output logic [DATA_W-1:0] d0_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_req    <= 1'b0;
         rd_addr_q <= '0;
         wr_req    <= 1'b0;
         be0_q     <= '0;
         d0_q      <= '0;
      end else if (k_phase == PH_RISE) begin
         rd_req    <= ~rd_n;
         rd_addr_q <= rd_addr;
         wr_req    <= ~wr_n;
         be0_q     <= ~bw_n;
         d0_q      <= din;
      end
   end

endmodule

// File: rtl/sbs_pair_array.sv
// Word-pair storage: masked pair commit, registered pair fetch.
module sbs_pair_array
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int DATA_W = LANES * LANE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [BEATS*LANES-1:0]  wbe,
   input  logic [BEATS*DATA_W-1:0] wdata,
   input  logic                    fetch_tick,
   input  logic                    rd_req,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [BEATS*DATA_W-1:0] rpair,
   output logic                    rvalid
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = BEATS * DATA_W;
   localparam int NSEG  = BEATS * LANES;

   logic [PW-1:0] mem [DEPTH];
   logic [PW-1:0] wmask;

   // One lane-wide mask segment per (beat, lane) strobe
   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      assign wmask[g*LANE_W +: LANE_W] = {LANE_W{wbe[g]}};
   end

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
      end
   end

   always_ff @(posedge clk) begin
      if (fetch_tick && rd_req) begin
         rpair <= mem[raddr];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
      end else if (fetch_tick) begin
         rvalid <= rd_req;
      end
   end

endmodule

// File: rtl/sbs_burst_out.sv
// Serialises a fetched pair into two half-cycle beats.
module sbs_burst_out
   import sbs_pkg::*;
#(
   parameter int DATA_W = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    k_phase,
   input  logic                    rvalid,
   input  logic [BEATS*DATA_W-1:0] rpair,
   output logic [DATA_W-1:0]       dout,
   output logic                    dout_valid
);

   localparam int PW = BEATS * DATA_W;

   logic hi_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout       <= '0;
         dout_valid <= 1'b0;
         hi_pend    <= 1'b0;
      end else if (k_phase == PH_FALL) begin
         dout_valid <= rvalid;
         hi_pend    <= rvalid;
         if (rvalid) begin
            dout <= rpair[DATA_W-1:0];
         end
      end else begin
         dout_valid <= hi_pend;
         hi_pend    <= 1'b0;
         if (hi_pend) begin
            dout <= rpair[PW-1:DATA_W];
         end
      end
   end

endmodule

// File: rtl/sp_burst2_sram.sv
module sp_burst2_sram
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      k_phase,
   input  logic                      rd_n,
   input  logic [ADDR_W-1:0]         rd_addr,
   input  logic                      wr_n,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [LANES-1:0]          bw_n,
   input  logic [LANES*LANE_W-1:0]   din,
   output logic [LANES*LANE_W-1:0]   dout,
   output logic                      dout_valid
);

   localparam int DATA_W = LANES * LANE_W;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("sp_burst2_sram: LANES and LANE_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("sp_burst2_sram: ADDR_W must be in 1..12");
   end

   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr_q;
   logic              wr_req;
   logic [LANES-1:0]  be0_q;
   logic [DATA_W-1:0] d0_q;
   logic              commit;
   logic [BEATS*DATA_W-1:0] rpair;
   logic              rvalid;

   sbs_cmd_capture #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .DATA_W (DATA_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .k_phase   (k_phase),
      .rd_n      (rd_n),
      .rd_addr   (rd_addr),
      .wr_n      (wr_n),
      .bw_n      (bw_n),
      .din       (din),
      .rd_req    (rd_req),
      .rd_addr_q (rd_addr_q),
      .wr_req    (wr_req),
      .be0_q     (be0_q),
      .d0_q      (d0_q)
   );

   // Write pair completes on the complementary half edge
   assign commit = wr_req && (k_phase == PH_FALL);

   sbs_pair_array #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .DATA_W (DATA_W)
   ) u_arr (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (commit),
      .waddr      (wr_addr),
      .wbe        ({~bw_n, be0_q}),
      .wdata      ({din, d0_q}),
      .fetch_tick (k_phase == PH_RISE),
      .rd_req     (rd_req),
      .raddr      (rd_addr_q),
      .rpair      (rpair),
      .rvalid     (rvalid)
   );

   sbs_burst_out #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .k_phase    (k_phase),
      .rvalid     (rvalid),
      .rpair      (rpair),
      .dout       (dout),
      .dout_valid (dout_valid)
   );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
   input logic clk,
   input logic rst_n,
   input logic k_phase,
   input logic rd_n,
   input logic dout_valid
);

   // R1: no read beat while in reset
   a_r1_idle_in_reset: assert property (@(posedge clk)
      !rst_n |=> !dout_valid);

   // R2: phase flag strictly alternates
   a_r2_phase_rise_then_fall: assert property (@(posedge clk) disable iff (!rst_n)
      k_phase |=> !k_phase);
   a_r2_phase_fall_then_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !k_phase |=> k_phase);

   // R2: every first beat traces back to a read taken on a rising-half edge
   a_r2_no_spurious_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && k_phase) |-> $past(k_phase && !rd_n, 4));

   // R7: read command yields a beat four samples later
   a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (k_phase && !rd_n) |-> ##4 dout_valid);

   // R8: bursts start on the right phase and are two beats long
   a_r8_burst_starts_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_valid) |-> k_phase);
   a_r8_second_beat_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && k_phase) |=> dout_valid);
   a_r8_second_beat_has_first: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && !k_phase) |-> $past(dout_valid));

endmodule

bind sp_burst2_sram sbs_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .k_phase    (k_phase),
   .rd_n       (rd_n),
   .dout_valid (dout_valid)
);

// File: tb/sp_burst2_sram_tb.sv
module sp_burst2_sram_tb;
   localparam int AW = 6;
   localparam int NL = 2;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          k_phase = 1'b0;
   logic          rd_n = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic          wr_n = 1'b1;
   logic [AW-1:0] wr_addr = '0;
   logic [NL-1:0] bw_n = '1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_valid;

   sp_burst2_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .k_phase    (k_phase),
      .rd_n       (rd_n),
      .rd_addr    (rd_addr),
      .wr_n       (wr_n),
      .wr_addr    (wr_addr),
      .bw_n       (bw_n),
      .din        (din),
      .dout       (dout),
      .dout_valid (dout_valid)
   );

   always #2 clk = ~clk;

   int hc = 0;
   always @(posedge clk) hc <= hc + 1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [DW-1:0] mdl [64][2];
   int            cap_h[$];
   logic [DW-1:0] cap_d[$];
   int            exp_h[$];
   logic [DW-1:0] exp_d[$];

   always @(negedge clk) begin
      if (rst_n && dout_valid) begin
         cap_h.push_back(hc);
         cap_d.push_back(dout);
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                           input logic [NL-1:0] bwn);
      logic [DW-1:0] r;
      r = o;
      for (int l = 0; l < NL; l++) if (!bwn[l]) r[l*LW +: LW] = n[l*LW +: LW];
      return r;
   endfunction

   task automatic half(input logic kp, input logic rdn, input logic [AW-1:0] ra, input logic wrn,
                       input logic [AW-1:0] wa, input logic [NL-1:0] bwn, input logic [DW-1:0] d);
      k_phase = kp; rd_n = rdn; rd_addr = ra; wr_n = wrn; wr_addr = wa; bw_n = bwn; din = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   // One command cycle; ignored inputs carry deliberate garbage (R2, R3)
   task automatic kcyc(input logic rdn, input logic [AW-1:0] ra, input logic wrn, input logic [AW-1:0] wa,
                       input logic [NL-1:0] bw0, input logic [DW-1:0] d0,
                       input logic [NL-1:0] bw1, input logic [DW-1:0] d1);
      int h0;
      half(1'b1, rdn, ra, wrn, ~wa, bw0, d0);
      h0 = hc;
      if (rst_n && !wrn) begin
         mdl[wa][0] = merge(mdl[wa][0], d0, bw0);
         mdl[wa][1] = merge(mdl[wa][1], d1, bw1);
      end
      if (rst_n && !rdn) begin
         exp_h.push_back(h0 + 3); exp_d.push_back(mdl[ra][0]);
         exp_h.push_back(h0 + 4); exp_d.push_back(mdl[ra][1]);
      end
      half(1'b0, 1'b0, ~ra, 1'b0, wa, bw1, d1);
   endtask

   task automatic idle();
      kcyc(1'b1, '0, 1'b1, '0, '1, '0, '0, '1);
   endtask

   task automatic rd(input logic [AW-1:0] a);
      kcyc(1'b0, a, 1'b1, '0, '0, '1, '0, '1);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bw0, input logic [DW-1:0] d0,
                     input logic [NL-1:0] bw1, input logic [DW-1:0] d1);
      kcyc(1'b1, '0, 1'b0, a, bw0, d0, bw1, d1);
   endtask

   task automatic drain(input string tag);
      int n;
      repeat (4) idle();
      check(cap_h.size() == exp_h.size(), {tag, " beat count"}, cap_h.size(), exp_h.size());
      n = (cap_h.size() < exp_h.size()) ? cap_h.size() : exp_h.size();
      for (int i = 0; i < n; i++) begin
         check(cap_h[i] == exp_h[i], {tag, " beat edge"}, cap_h[i], exp_h[i]);
         check(cap_d[i] === exp_d[i], {tag, " beat data"}, cap_d[i], exp_d[i]);
      end
      cap_h.delete(); cap_d.delete(); exp_h.delete(); exp_d.delete();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) idle();
      check(dout_valid === 1'b0, "R1 valid in reset", dout_valid, 0);
      rst_n = 1'b1;
      idle();
      check(dout_valid === 1'b0, "R1 valid after reset", dout_valid, 0);
      check(dout === '0, "R1 dout after reset", dout, 0);
   endtask

   task automatic t_fill();
      for (int a = 0; a < 8; a++)
         wr(AW'(a), '0, DW'(18'h01000 + a * 18'h111), '0, DW'(18'h20000 + a * 18'h0A5));
      for (int a = 0; a < 8; a++) begin
         rd(AW'(a));
         idle();
      end
      drain("R7 R3 full pair write and read latency");
   endtask

   task automatic t_ignore();
      repeat (3) idle();
      drain("R2 no beats from garbage on ignored half");
      rd(6'd0);
      drain("R2 pair untouched by ignored-half strobes");
   endtask

   task automatic t_bytes();
      wr(6'd2, 2'b10, 18'h3A5C3, 2'b01, 18'h15A3C);
      rd(6'd2);
      drain("R4 per-beat lane strobes");
   endtask

   task automatic t_abort();
      wr(6'd3, 2'b11, 18'h3FFFF, 2'b11, 18'h3FFFF);
      rd(6'd3);
      drain("R5 abort with all strobes high");
      kcyc(1'b1, '0, 1'b1, 6'd4, '0, 18'h2AAAA, '0, 18'h15555);
      rd(6'd4);
      drain("R6 write disabled");
   endtask

   task automatic t_b2b();
      rd(6'd0); rd(6'd1); rd(6'd5); rd(6'd6);
      drain("R8 back-to-back stream");
   endtask

   task automatic t_concurrent();
      kcyc(1'b0, 6'd6, 1'b0, 6'd7, '0, 18'h0F0F0, '0, 18'h30303);
      rd(6'd7);
      drain("R9 same-cycle read and write to different pairs");
   endtask

   task automatic t_coherent();
      kcyc(1'b0, 6'd1, 1'b0, 6'd1, 2'b01, 18'h3C000, 2'b10, 18'h000C3);
      drain("R10 same-cycle merge");
      rd(6'd0);
      wr(6'd0, '0, 18'h12345, '0, 18'h2BCDE);
      rd(6'd0);
      drain("R10 read before write sees old");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_fill();
      t_ignore();
      t_bytes();
      t_abort();
      t_b2b();
      t_concurrent();
      t_coherent();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule